// File: doc/BRIEF.md
# Event Counter Bank with Overflow Freeze

This block holds a bank of free-running event counters for hardware performance monitoring. Each counter adds one on every cycle in which its event input is high. Counting happens only while a global freeze flag is clear. When a counter rolls over from all-ones to zero, it latches a sticky overflow flag in a status vector. If that counter is armed for interrupts, the rollover also raises the freeze flag, which stops the whole bank and holds the status flags where they are. The same rollover asks for an overflow interrupt. A mask bit can keep that request from being latched as pending.

Software reaches the counters, the status words (the freeze flag is bit 0 of the first one), the per-counter interrupt arm vector and an interrupt control word through a simple register port. Writes take effect at the clock edge and reads are combinational. A monitor elsewhere in the chip can also raise the freeze flag, and request the interrupt, through a dedicated input. Counting resumes only after software writes the freeze flag back to zero.

Top module: `pmu_frz_unit`

## Requirements
- R1: While the freeze flag is 0, a counter whose event input is high at a clock edge adds one, and it wraps from all-ones to zero. A counter whose event input is low keeps its value.
- R2: While the freeze flag is 1, no counter changes except by a software write, and no status bit changes except by a software write.
- R3: A rollover of counter n, with n of 4 or more, sets status bit n (bit n mod 32 of status word n/32). A status bit is cleared only by a software write to its word. Rollovers of several counters in the same cycle all set their bits, whether or not they are armed.
- R4: Counters 0 to 3 have no status bit. Status bits 3:1, and the status bits of counters that are not implemented, always read 0, and writes to them are dropped.
- R5: A rollover of a counter whose bit in the arm vector (address 0x11, bit i for counter i) is 1 sets the freeze flag at the next edge. A rollover of a counter that is not armed leaves the freeze flag unchanged.
- R6: A high level on the external monitor input sets the freeze flag and raises an interrupt request in that cycle.
- R7: Software may write the freeze flag (status word 0 at address 0x00, bit 0) to 1 or to 0. After a write of 0, counting resumes from the next cycle on.
- R8: A software write to a status word overrides any hardware set of a bit in that word in the same cycle. This includes the freeze flag.
- R9: An interrupt request sets the pending flag at the next edge only if the mask bit held before that edge is 0. The mask bit is bit 0 and the pending flag is bit 1 of the control word at address 0x10.
- R10: The pending flag stays set until software writes a 1 to control bit 1. If a new request arrives in the same cycle as that clear, the flag stays set.
- R11: A software write to counter i (address 0x20+i) loads its value even while the bank is frozen. If an event arrives in the same cycle, the write wins, and no increment or rollover happens.
- R12: After reset, all counters, status bits, the freeze flag, the arm vector and the pending flag are 0, and the mask bit is 1.
- R13: A read of an address outside the map (status words, 0x10, 0x11, 0x20 to 0x27) returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | NUM_CTR | Per-counter event strobes |
| ext_mon_irq | input | 1 | Interrupt signal from an external monitor; sets freeze |
| sw_wr_en | input | 1 | Register write strobe |
| sw_wr_addr | input | 6 | Register write address |
| sw_wr_data | input | REG_W | Register write data |
| sw_rd_addr | input | 6 | Register read address |
| sw_rd_data | output | REG_W | Register read data, combinational |
| irq_pending | output | 1 | Latched overflow interrupt |

## Verification
The bench preloads counters to within a step of all-ones so that rollovers happen often. It checks that an armed rollover freezes the bank one edge later. A design that froze in the same cycle, or one that gated on the new freeze value, would lose or add one increment on the other counters. It drives a status write in the same cycle as a rollover and as the external interrupt, where a design with the wrong priority would show a set bit or a stuck freeze. It clears the pending flag in the same cycle as a new request, where a wrong design would drop the interrupt. It also writes all-ones to the status word, where a design that did not drop the reserved bits would read back more than bits 7:4 and the freeze flag.

// File: rtl/pmu_frz_pkg.sv
package pmu_frz_pkg;

    localparam int ADDR_W   = 6;
    localparam int RSVD_LOW = 4;   // status positions below this never report

    localparam logic [ADDR_W-1:0] A_STAT = 6'h00;
    localparam logic [ADDR_W-1:0] A_CTRL = 6'h10;
    localparam logic [ADDR_W-1:0] A_OIEN = 6'h11;
    localparam logic [ADDR_W-1:0] A_CTR  = 6'h20;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_STAT,
        TGT_CTRL,
        TGT_OIEN,
        TGT_CTR
    } reg_tgt_e;

    typedef struct packed {
        reg_tgt_e   tgt;
        logic [4:0] idx;
    } reg_sel_t;

    function automatic reg_sel_t decode(input logic [ADDR_W-1:0] a,
                                        input int n_sword, input int n_ctr);
        reg_sel_t s;
        s.tgt = TGT_NONE;
        s.idx = a[4:0];
        if (a == A_CTRL)                                     s.tgt = TGT_CTRL;
        else if (a == A_OIEN)                                s.tgt = TGT_OIEN;
        else if (a[5] && (int'(a[4:0]) < n_ctr))             s.tgt = TGT_CTR;
        else if (!a[5] && !a[4] && (int'(a[3:0]) < n_sword)) s.tgt = TGT_STAT;
        return s;
    endfunction

endpackage

// File: rtl/pmu_frz_counter.sv
module pmu_frz_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         frozen,
    input  logic         evt,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] value,
    output logic         wrap
);
    logic bump;

    always_comb begin
        bump = evt && !frozen && !wr_en;
        wrap = bump && (&value);
    end

    always_ff @(posedge clk) begin
        if (rst)        value <= '0;
        else if (wr_en) value <= wdata;
        else if (bump)  value <= value + 1'b1;
    end
endmodule

// File: rtl/pmu_frz_status.sv
module pmu_frz_status #(
    parameter int REG_W   = 32,
    parameter int NUM_CTR = 8,
    parameter int LOW     = 4,
    parameter int NSW     = 1,
    localparam int SBITS  = NSW * REG_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_CTR-1:0] wrap,
    input  logic [NUM_CTR-1:0] oien,
    input  logic               ext_irq,
    input  logic [NSW-1:0]     stat_wr,
    input  logic [REG_W-1:0]   wdata,
    output logic               freeze,
    output logic [SBITS-1:0]   sticky,
    output logic               irq_req
);
    function automatic logic [SBITS-1:0] mk_live();
        logic [SBITS-1:0] m;
        for (int j = 0; j < SBITS; j++) m[j] = (j >= LOW) && (j < NUM_CTR);
        return m;
    endfunction
    localparam logic [SBITS-1:0] LIVE = mk_live();

    logic [SBITS-1:0] wrap_ext;
    logic [SBITS-1:0] word_nxt;

    assign wrap_ext = SBITS'(wrap);
    assign irq_req  = (|(wrap & oien)) | ext_irq;

    for (genvar w = 0; w < NSW; w++) begin : g_word
        assign word_nxt[w*REG_W +: REG_W] = stat_wr[w] ? wdata
            : (sticky[w*REG_W +: REG_W] | wrap_ext[w*REG_W +: REG_W]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sticky <= '0;
            freeze <= 1'b0;
        end else begin
            sticky <= word_nxt & LIVE;
            freeze <= stat_wr[0] ? wdata[0] : (freeze | irq_req);
        end
    end
endmodule

// File: rtl/pmu_frz_irq.sv
module pmu_frz_irq (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic wr_ctrl,
    input  logic wr_mask,
    input  logic wr_clr,
    output logic mask,
    output logic pending
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mask    <= 1'b1;
            pending <= 1'b0;
        end else begin
            if (wr_ctrl) mask <= wr_mask;
            pending <= (pending & ~(wr_ctrl & wr_clr)) | (req & ~mask);
        end
    end
endmodule

// File: rtl/pmu_frz_unit.sv
module pmu_frz_unit
    import pmu_frz_pkg::*;
#(
    parameter int NUM_CTR = 8,
    parameter int REG_W   = 32,
    localparam int NSW    = (NUM_CTR + REG_W - 1) / REG_W,
    localparam int SBITS  = NSW * REG_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_CTR-1:0] evt_in,
    input  logic               ext_mon_irq,
    input  logic               sw_wr_en,
    input  logic [ADDR_W-1:0]  sw_wr_addr,
    input  logic [REG_W-1:0]   sw_wr_data,
    input  logic [ADDR_W-1:0]  sw_rd_addr,
    output logic [REG_W-1:0]   sw_rd_data,
    output logic               irq_pending
);
    reg_sel_t wsel, rsel;
    logic [NUM_CTR-1:0][REG_W-1:0] ctr_val;
    logic [NUM_CTR-1:0] ctr_wr, wrap;
    logic [NSW-1:0]     stat_wr;
    logic [NUM_CTR-1:0] oien;
    logic [SBITS-1:0]   sticky;
    logic freeze, irq_req, mask, ctrl_wr;

    always_comb begin
        wsel = decode(sw_wr_addr, NSW, NUM_CTR);
        rsel = decode(sw_rd_addr, NSW, NUM_CTR);
        ctrl_wr = sw_wr_en && (wsel.tgt == TGT_CTRL);
    end

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
        assign ctr_wr[i] = sw_wr_en && (wsel.tgt == TGT_CTR) && (int'(wsel.idx) == i);
        pmu_frz_counter #(.W(REG_W)) u_ctr (
            .clk(clk), .rst(rst), .frozen(freeze), .evt(evt_in[i]),
            .wr_en(ctr_wr[i]), .wdata(sw_wr_data),
            .value(ctr_val[i]), .wrap(wrap[i])
        );
    end

    for (genvar w = 0; w < NSW; w++) begin : g_swr
        assign stat_wr[w] = sw_wr_en && (wsel.tgt == TGT_STAT) && (int'(wsel.idx) == w);
    end

    always_ff @(posedge clk) begin
        if (rst) oien <= '0;
        else if (sw_wr_en && (wsel.tgt == TGT_OIEN)) oien <= sw_wr_data[NUM_CTR-1:0];
    end

    pmu_frz_status #(.REG_W(REG_W), .NUM_CTR(NUM_CTR), .LOW(RSVD_LOW), .NSW(NSW)) u_stat (
        .clk(clk), .rst(rst), .wrap(wrap), .oien(oien), .ext_irq(ext_mon_irq),
        .stat_wr(stat_wr), .wdata(sw_wr_data),
        .freeze(freeze), .sticky(sticky), .irq_req(irq_req)
    );

    pmu_frz_irq u_irq (
        .clk(clk), .rst(rst), .req(irq_req), .wr_ctrl(ctrl_wr),
        .wr_mask(sw_wr_data[0]), .wr_clr(sw_wr_data[1]),
        .mask(mask), .pending(irq_pending)
    );

    always_comb begin
        sw_rd_data = '0;
        case (rsel.tgt)
            TGT_CTRL: sw_rd_data = REG_W'({irq_pending, mask});
            TGT_OIEN: sw_rd_data = REG_W'(oien);
            TGT_CTR: begin
                for (int i = 0; i < NUM_CTR; i++)
                    if (int'(rsel.idx) == i) sw_rd_data = ctr_val[i];
            end
            TGT_STAT: begin
                for (int w = 0; w < NSW; w++)
                    if (int'(rsel.idx) == w) sw_rd_data = sticky[w*REG_W +: REG_W];
                if (rsel.idx == 5'd0) sw_rd_data[0] = freeze;
            end
            default: sw_rd_data = '0;
        endcase
    end
endmodule

// File: rtl/pmu_frz_unit_chk.sv
module pmu_frz_unit_chk #(
    parameter int NUM_CTR = 8,
    parameter int REG_W   = 32,
    parameter int SBITS   = 32
) (
    input logic                          clk,
    input logic                          rst,
    input logic [NUM_CTR-1:0][REG_W-1:0] ctr_val,
    input logic [NUM_CTR-1:0]            ctr_wr,
    input logic [NUM_CTR-1:0]            wrap,
    input logic [NUM_CTR-1:0]            oien,
    input logic [SBITS-1:0]              sticky,
    input logic                          freeze,
    input logic                          stat_wr0,
    input logic                          stat_wr_any,
    input logic                          wr_bit0,
    input logic                          ext_irq,
    input logic                          irq_req,
    input logic                          mask,
    input logic                          pending,
    input logic                          rd_is_stat0,
    input logic [2:0]                    rd_rsvd
);
    for (genvar i = 0; i < NUM_CTR; i++) begin : g_hold
        AST_FROZEN_CTR_HOLD: assert property (@(posedge clk) disable iff (rst)
            (freeze && !ctr_wr[i]) |=> $stable(ctr_val[i])); // R2
    end

    AST_FROZEN_STAT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (freeze && !stat_wr_any) |=> $stable(sticky)); // R2
    AST_NO_WRAP_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (|wrap) |-> !freeze); // R2
    AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (rst)
        !stat_wr_any |=> ((sticky & $past(sticky)) == $past(sticky))); // R3
    AST_ARMED_FREEZE: assert property (@(posedge clk) disable iff (rst)
        ((|(wrap & oien)) && !stat_wr0) |=> freeze); // R5
    AST_EXT_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (ext_irq && !stat_wr0) |=> freeze); // R6
    AST_SW_WINS: assert property (@(posedge clk) disable iff (rst)
        stat_wr0 |=> (freeze == $past(wr_bit0))); // R8
    AST_PEND_SET: assert property (@(posedge clk) disable iff (rst)
        (irq_req && !mask) |=> pending); // R9
    AST_PEND_SOURCE: assert property (@(posedge clk) disable iff (rst)
        $rose(pending) |-> $past(irq_req && !mask)); // R9
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        rd_is_stat0 |-> (rd_rsvd == 3'b000)); // R4
endmodule

bind pmu_frz_unit pmu_frz_unit_chk #(
    .NUM_CTR(NUM_CTR), .REG_W(REG_W), .SBITS(SBITS)
) chk_i (
    .clk(clk), .rst(rst), .ctr_val(ctr_val), .ctr_wr(ctr_wr), .wrap(wrap),
    .oien(oien), .sticky(sticky), .freeze(freeze), .stat_wr0(stat_wr[0]),
    .stat_wr_any(|stat_wr), .wr_bit0(sw_wr_data[0]), .ext_irq(ext_mon_irq),
    .irq_req(irq_req), .mask(mask), .pending(irq_pending),
    .rd_is_stat0(sw_rd_addr == 6'h00), .rd_rsvd(sw_rd_data[3:1])
);

// File: tb/pmu_frz_unit_tb_top.sv
module pmu_frz_unit_tb_top;
    localparam int CLK_PERIOD = 100;
    localparam int NC = 8;
    localparam logic [31:0] MAXV = 32'hFFFF_FFFF;
    localparam logic [31:0] LIVE = 32'h0000_00F0;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NC-1:0] evt_in = '0;
    logic ext_mon_irq = 1'b0;
    logic sw_wr_en = 1'b0;
    logic [5:0] sw_wr_addr = '0;
    logic [31:0] sw_wr_data = '0;
    logic [5:0] sw_rd_addr = '0;
    logic [31:0] sw_rd_data;
    logic irq_pending;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] m_ctr [NC];
    logic [31:0] m_st;
    logic m_frz, m_mask, m_pend;
    logic [NC-1:0] m_oien;
    logic [31:0] n_ctr [NC];
    logic [31:0] n_st;
    logic n_frz, n_mask, n_pend;
    logic [NC-1:0] n_oien;

    pmu_frz_unit dut_i (
        .clk(clk), .rst(rst), .evt_in(evt_in), .ext_mon_irq(ext_mon_irq),
        .sw_wr_en(sw_wr_en), .sw_wr_addr(sw_wr_addr), .sw_wr_data(sw_wr_data),
        .sw_rd_addr(sw_rd_addr), .sw_rd_data(sw_rd_data), .irq_pending(irq_pending)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        summary();
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s addr=%02h got=%08h expected=%08h", tag, sw_rd_addr, got, exp);
        end
    endtask

    function automatic logic [31:0] expect_rd(input logic [5:0] a);
        if (a == 6'h00) return m_st | {31'd0, m_frz};
        if (a == 6'h10) return {30'd0, m_pend, m_mask};
        if (a == 6'h11) return {24'd0, m_oien};
        if (a >= 6'h20 && a < 6'h28) return m_ctr[a - 6'h20];
        return 32'd0;
    endfunction

    task automatic check_all(input string tag);
        logic [5:0] alist [13] = '{6'h00, 6'h01, 6'h10, 6'h11, 6'h20, 6'h21, 6'h22,
                                   6'h23, 6'h24, 6'h25, 6'h26, 6'h27, 6'h3F};
        for (int k = 0; k < 13; k++) begin
            sw_rd_addr = alist[k];
            #1;
            check(alist[k] == 6'h01 || alist[k] == 6'h3F ? "R13" : tag,
                  sw_rd_data, expect_rd(alist[k]));
        end
        n_chk++;
        if (irq_pending !== m_pend) begin
            n_bad++;
            $display("FAIL %s irq_pending got=%0b expected=%0b", tag, irq_pending, m_pend);
        end
    endtask

    task automatic model_next(input logic [NC-1:0] ev, input logic ext, input logic we,
                              input logic [5:0] wa, input logic [31:0] wd);
        logic [NC-1:0] wrapped;
        logic req;
        wrapped = '0;
        for (int i = 0; i < NC; i++) begin
            n_ctr[i] = m_ctr[i];
            if (we && wa == 6'h20 + 6'(i)) n_ctr[i] = wd;
            else if (ev[i] && !m_frz) begin
                n_ctr[i] = m_ctr[i] + 32'd1;
                wrapped[i] = (m_ctr[i] == MAXV);
            end
        end
        req = ext || (|(wrapped & m_oien));
        n_st = m_st | ({24'd0, wrapped} & LIVE);
        n_frz = m_frz | req;
        if (we && wa == 6'h00) begin
            n_st = wd & LIVE;
            n_frz = wd[0];
        end
        n_mask = (we && wa == 6'h10) ? wd[0] : m_mask;
        n_pend = (m_pend && !(we && wa == 6'h10 && wd[1])) || (req && !m_mask);
        n_oien = (we && wa == 6'h11) ? wd[NC-1:0] : m_oien;
    endtask

    task automatic step(input logic [NC-1:0] ev, input logic ext, input logic we,
                        input logic [5:0] wa, input logic [31:0] wd);
        evt_in = ev; ext_mon_irq = ext; sw_wr_en = we; sw_wr_addr = wa; sw_wr_data = wd;
        model_next(ev, ext, we, wa, wd);
        @(posedge clk);
        for (int i = 0; i < NC; i++) m_ctr[i] = n_ctr[i];
        m_st = n_st; m_frz = n_frz; m_mask = n_mask; m_pend = n_pend; m_oien = n_oien;
        @(negedge clk);
        evt_in = '0; ext_mon_irq = 1'b0; sw_wr_en = 1'b0;
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        step('0, 1'b0, 1'b1, a, d);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NC; i++) m_ctr[i] = '0;
        m_st = '0; m_frz = 1'b0; m_mask = 1'b1; m_pend = 1'b0; m_oien = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_all("R12");                       // reset values

        step(8'h0F, 1'b0, 1'b0, 6'h00, 0);      // R1 basic increment
        step(8'hA5, 1'b0, 1'b0, 6'h00, 0);
        check_all("R1");

        wr(6'h10, 32'd0);                       // unmask
        wr(6'h24, MAXV); wr(6'h27, MAXV);
        step(8'h90, 1'b0, 1'b0, 6'h00, 0);      // R3 two wraps unarmed, same cycle
        check_all("R3");

        wr(6'h11, 32'h20); wr(6'h25, MAXV);
        step(8'h20, 1'b0, 1'b0, 6'h00, 0);      // R5 armed wrap
        check_all("R5");
        step(8'hFF, 1'b0, 1'b0, 6'h00, 0);      // R2 frozen: nothing moves
        check_all("R2");
        wr(6'h22, 32'h1234);                    // R11 write while frozen
        check_all("R11");

        step(8'h00, 1'b1, 1'b1, 6'h10, 32'h2);  // R10 clear with new request
        check_all("R10");
        wr(6'h10, 32'h2);                       // R10 plain clear
        check_all("R10");

        wr(6'h00, 32'h0);                       // R7 resume
        step(8'h04, 1'b0, 1'b0, 6'h00, 0);
        check_all("R7");
        wr(6'h00, 32'h1);                       // R7 freeze by write
        step(8'h04, 1'b0, 1'b0, 6'h00, 0);
        check_all("R7");

        wr(6'h00, 32'h0); wr(6'h11, 32'h40); wr(6'h26, MAXV);
        step(8'h40, 1'b0, 1'b1, 6'h00, 32'h0);  // R8 write beats wrap set
        check_all("R8");
        step(8'h00, 1'b1, 1'b1, 6'h00, 32'h0);  // R8 write beats ext freeze
        check_all("R8");

        wr(6'h00, 32'hFFFF_FFFF);               // R4 reserved bits dropped
        check_all("R4");
        wr(6'h00, 32'h0); wr(6'h11, 32'h01); wr(6'h20, MAXV);
        step(8'h01, 1'b0, 1'b0, 6'h00, 0);      // R4 ctr0 wrap: no status bit, freezes
        check_all("R4");

        wr(6'h00, 32'h0);
        step(8'h00, 1'b1, 1'b0, 6'h00, 0);      // R6 external freeze
        check_all("R6");
        wr(6'h10, 32'h3);                       // mask on, clear
        wr(6'h00, 32'h0);
        step(8'h00, 1'b1, 1'b0, 6'h00, 0);      // R9 masked: no pending
        check_all("R9");

        wr(6'h00, 32'h0); wr(6'h23, MAXV);
        step(8'h08, 1'b0, 1'b1, 6'h23, 32'h77); // R11 write wins over event
        check_all("R11");

        for (int c = 0; c < 3000; c++) begin
            logic [NC-1:0] ev;
            logic ext, we;
            logic [5:0] wa;
            logic [31:0] wd;
            int pick;
            ev = 8'($urandom);
            ext = ($urandom % 40) == 0;
            we = ($urandom % 4) == 0;
            pick = int'($urandom % 8);
            wd = $urandom;
            case (pick)
                0, 1: wa = 6'h00;
                2:    wa = 6'h10;
                3:    wa = 6'h11;
                default: begin
                    wa = 6'h20 + 6'($urandom % NC);
                    if ($urandom % 2 == 0) wd = MAXV - ($urandom % 3);
                end
            endcase
            step(ev, ext, we, wa, wd);
            check_all("R1");
        end
        summary();
    end
endmodule